// File: doc/BRIEF.md
# General-Purpose Pin Bank with Interrupt Cause Logic

This block is a bank of general-purpose pins controlled through a small register file. Software can do three things with it. It can write a value for each pin and choose, pin by pin, whether that value is driven. It can read back the pin levels after they pass through synchronisers and an optional per-pin inversion. It can make any pin output a square wave instead of its written value.

The pin levels, after synchronising and inversion, also feed interrupt logic. A rising edge on an adjusted pin latches a pending bit. Software removes pending bits by writing zeros to them. One interrupt line combines the masked pending edges with the masked live levels. The register interface has a write strobe and an address, and its read data is combinational. There is one register per address and one bit per pin.

Top module: `gpio_bank`

## Requirements
- R1: After reset the following hold. Data-out, blink enable, inversion and both mask registers are zero. The drive-off register is all ones, so no pin is driven. The pending register is zero while the pins are low, and `irq` is low.
- R2: The register map uses these addresses: 0 data-out, 1 drive-off, 2 blink enable, 3 inversion, 4 pin state (read-only), 5 edge pending, 6 edge mask, 7 level mask. A write to address 0, 1, 2, 3, 6 or 7 takes effect at the clock edge that samples it, and reads back unchanged.
- R3: The drive-off register is active-low. `pinDriveEn[i]` is 1 exactly when bit i of the drive-off register is 0. When blink is off for a pin, `pinOut[i]` equals data-out bit i.
- R4: Reading address 4 returns each pin XOR its inversion bit. The pin value passes through SYNC_STAGES (default 2) flip-flops, so a pin change shows up after that many clock edges.
- R5: A pending bit is set one clock edge after a rising edge of its adjusted pin level. That is SYNC_STAGES+1 edges after the pin changes. A falling edge sets nothing.
- R6: When address 5 is written, a data bit of 0 clears that pending bit and a data bit of 1 leaves it as it is. Writing all zeros clears every pending bit.
- R7: A pending bit whose rising edge is registered at the same clock edge as a clearing write ends up set.
- R8: `irq` is high whenever some bit is set in both the pending register and the edge mask.
- R9: `irq` is high whenever some bit is set in both the adjusted pin state and the level mask. Apart from R8 and this case, `irq` is low.
- R10: For a pin whose blink bit is 1, `pinOut` ignores data-out and toggles every 2^(BLINK_LOG2-1) clock cycles (every 8 cycles by default). The timing comes from a free-running counter.
- R11: Writes to the pin-state address have no effect. The pin state read afterwards still equals the pins XOR inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| pinIn | input | 32 | Raw pin levels |
| pinOut | output | 32 | Output value per pin |
| pinDriveEn | output | 32 | Per-pin drive enable, high = driven |
| irq | output | 1 | Combined edge and level interrupt |

## Verification
Some properties are checked by the assertions on every cycle:
- No pending bit drops except during a write to the pending register.
- No pending bit appears without a registered rising edge.
- The interrupt stays low while both masks are clear.
- At most one register write strobe is active.

Other behaviour can only be shown by the bench's scenarios:
- The synchroniser and pending-set latencies.
- Inversion applied before edge detection.
- A set winning against a same-cycle clear.
- The exact blink half-period.
- The ignored write to the pin-state address.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_OUT    = 3'd0,
    RA_DRVOFF = 3'd1,
    RA_BLINK  = 3'd2,
    RA_INV    = 3'd3,
    RA_STATE  = 3'd4,
    RA_CAUSE  = 3'd5,
    RA_EDGEEN = 3'd6,
    RA_LVLEN  = 3'd7
  } regIdx_e;

  localparam int NUM_ADDR = 1 << ADDR_W;

  typedef struct packed {
    logic wrOut;
    logic wrDrvOff;
    logic wrBlink;
    logic wrInv;
    logic wrCause;
    logic wrEdgeEn;
    logic wrLvlEn;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int BLINK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobe_t         strobe,
  output logic              blinkPhase
);

  logic [NUM_ADDR-1:0]   wrSel;
  logic [BLINK_LOG2-1:0] blinkCnt;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_dec
    assign wrSel[g] = regWe && (regAddr == ADDR_W'(g));
  end

  always_comb begin
    strobe          = '0;
    strobe.wrOut    = wrSel[RA_OUT];
    strobe.wrDrvOff = wrSel[RA_DRVOFF];
    strobe.wrBlink  = wrSel[RA_BLINK];
    strobe.wrInv    = wrSel[RA_INV];
    strobe.wrCause  = wrSel[RA_CAUSE];
    strobe.wrEdgeEn = wrSel[RA_EDGEEN];
    strobe.wrLvlEn  = wrSel[RA_LVLEN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blinkCnt <= '0;
    else       blinkCnt <= blinkCnt + 1'b1;
  end

  assign blinkPhase = blinkCnt[BLINK_LOG2-1];

  // R2: address decode selects at most one register per write
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrSel));

  // R10: the blink phase never toggles in two successive cycles
  a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    (BLINK_LOG2 > 1 && blinkPhase != $past(blinkPhase)) |=> $stable(blinkPhase));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic              blinkPhase,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NPINS-1:0]  regWdata,
  output logic [NPINS-1:0]  regRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinDriveEn,
  output logic              irq
);

  logic [NPINS-1:0] dataOut, drvOff, blinkEn, invMask;
  logic [NPINS-1:0] cause, edgeMask, lvlMask;
  logic [NPINS-1:0] syncStage [SYNC_STAGES];
  logic [NPINS-1:0] pinState, prevState, riseVec;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= pinIn;
      else             syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end

  assign pinState = syncStage[SYNC_STAGES-1] ^ invMask;
  assign riseVec  = pinState & ~prevState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      drvOff    <= '1;
      blinkEn   <= '0;
      invMask   <= '0;
      edgeMask  <= '0;
      lvlMask   <= '0;
      cause     <= '0;
      prevState <= '0;
    end else begin
      prevState <= pinState;
      if (strobe.wrOut)    dataOut  <= regWdata;
      if (strobe.wrDrvOff) drvOff   <= regWdata;
      if (strobe.wrBlink)  blinkEn  <= regWdata;
      if (strobe.wrInv)    invMask  <= regWdata;
      if (strobe.wrEdgeEn) edgeMask <= regWdata;
      if (strobe.wrLvlEn)  lvlMask  <= regWdata;
      // a new edge overrides a clearing write in the same cycle
      cause <= (strobe.wrCause ? (cause & regWdata) : cause) | riseVec;
    end
  end

  always_comb begin
    case (regAddr)
      RA_OUT:    regRdata = dataOut;
      RA_DRVOFF: regRdata = drvOff;
      RA_BLINK:  regRdata = blinkEn;
      RA_INV:    regRdata = invMask;
      RA_STATE:  regRdata = pinState;
      RA_CAUSE:  regRdata = cause;
      RA_EDGEEN: regRdata = edgeMask;
      default:   regRdata = lvlMask;
    endcase
  end

  assign pinOut     = (blinkEn & {NPINS{blinkPhase}}) | (~blinkEn & dataOut);
  assign pinDriveEn = ~drvOff;
  assign irq        = (|(cause & edgeMask)) | (|(pinState & lvlMask));

  // R6: pending bits only drop during a write to the pending register
  a_r6_no_silent_clear: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCause |=> (($past(cause) & ~cause) == '0));

  // R5: a pending bit only appears after a registered rising edge
  a_r5_set_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(riseVec)) == '0));

  // R8/R9: no interrupt while both masks are clear
  a_r9_quiet_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMask == '0 && lvlMask == '0) |-> !irq);

  // R1: nothing is driven in the first cycle after reset
  a_r1_undriven: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinDriveEn == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int BLINK_LOG2  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NPINS-1:0]  regWdata,
  output logic [NPINS-1:0]  regRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinDriveEn,
  output logic              irq
);

  wrStrobe_t strobe;
  logic      blinkPhase;

  gpio_bank_ctrl #(.BLINK_LOG2(BLINK_LOG2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .strobe     (strobe),
    .blinkPhase (blinkPhase)
  );

  gpio_bank_dp #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .blinkPhase (blinkPhase),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .pinIn      (pinIn),
    .pinOut     (pinOut),
    .pinDriveEn (pinDriveEn),
    .irq        (irq)
  );

endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  localparam int HALF_BLINK = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinDriveEn;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinDriveEn(pinDriveEn), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] expRise(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] p);
    return (b ^ p) & ~(a ^ p);
  endfunction

  function automatic logic expIrq(input logic [31:0] c, input logic [31:0] em,
                                  input logic [31:0] st, input logic [31:0] lm);
    return (|(c & em)) | (|(st & lm));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, b, p, em, lm, w, expC;
    int seedDummy;
    int lastT, gap;
    seedDummy = $urandom(32'd2024);
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(3'd0, rd); chk("R1 data-out", rd, 32'h0);
    rdReg(3'd1, rd); chk("R1 drive-off", rd, 32'hFFFF_FFFF);
    rdReg(3'd2, rd); chk("R1 blink", rd, 32'h0);
    rdReg(3'd3, rd); chk("R1 inversion", rd, 32'h0);
    rdReg(3'd5, rd); chk("R1 pending", rd, 32'h0);
    rdReg(3'd6, rd); chk("R1 edge mask", rd, 32'h0);
    rdReg(3'd7, rd); chk("R1 level mask", rd, 32'h0);
    chk("R1 drive enable", pinDriveEn, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 / R3 readback and active-low drive
    wrReg(3'd0, 32'hA5C3_0F96);
    wrReg(3'd1, 32'h0000_FFFF);
    rdReg(3'd0, rd); chk("R2 data-out readback", rd, 32'hA5C3_0F96);
    rdReg(3'd1, rd); chk("R2 drive-off readback", rd, 32'h0000_FFFF);
    chk("R3 drive enable", pinDriveEn, 32'hFFFF_0000);
    chk("R3 pin out", pinOut, 32'hA5C3_0F96);

    // R4 synchroniser latency
    pinIn = 32'h0000_00F0;
    @(negedge clk);
    rdReg(3'd4, rd); chk("R4 state after one edge", rd, 32'h0);
    @(negedge clk);
    rdReg(3'd4, rd); chk("R4 state after two edges", rd, 32'h0000_00F0);
    // R5 pending appears one edge later
    rdReg(3'd5, rd); chk("R5 pending not yet", rd, 32'h0);
    @(negedge clk);
    rdReg(3'd5, rd); chk("R5 pending set", rd, 32'h0000_00F0);
    // R5 falling edge sets nothing
    wrReg(3'd5, 32'h0);
    pinIn = 32'h0;
    waitCyc(4);
    rdReg(3'd5, rd); chk("R5 falling edge", rd, 32'h0);

    // R11 write to pin state ignored
    pinIn = 32'h1234_5678;
    waitCyc(4);
    wrReg(3'd4, 32'hFFFF_FFFF);
    rdReg(3'd4, rd); chk("R11 state unchanged", rd, 32'h1234_5678);
    rdReg(3'd1, rd); chk("R11 no side write", rd, 32'h0000_FFFF);

    // R7 set wins over same-cycle clear
    pinIn = 32'h0;
    waitCyc(4);
    wrReg(3'd5, 32'h0);
    pinIn = 32'h0000_0008;
    waitCyc(4);
    pinIn = 32'h0000_0028;
    @(negedge clk);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd5; regWdata = 32'h0;
    @(negedge clk);
    regWe = 1'b0;
    rdReg(3'd5, rd); chk("R7 edge beats clear", rd, 32'h0000_0020);

    // Random scenarios: R4 R5 R6 R8 R9
    for (int it = 0; it < 24; it++) begin
      a = $urandom(); b = $urandom(); p = $urandom();
      em = (it % 3 == 0) ? 32'h0 : $urandom();
      lm = (it % 4 == 1) ? 32'h0 : ($urandom() & $urandom());
      wrReg(3'd6, 32'h0);
      wrReg(3'd7, 32'h0);
      pinIn = a;
      wrReg(3'd3, p);
      waitCyc(4);
      wrReg(3'd5, 32'h0);
      pinIn = b;
      waitCyc(4);
      expC = expRise(a, b, p);
      rdReg(3'd5, rd); chk("R5 random pending", rd, expC);
      rdReg(3'd4, rd); chk("R4 random state", rd, b ^ p);
      wrReg(3'd6, em);
      wrReg(3'd7, lm);
      chk("R8 R9 random irq", {31'h0, irq}, {31'h0, expIrq(expC, em, b ^ p, lm)});
      w = $urandom();
      wrReg(3'd5, w);
      rdReg(3'd5, rd); chk("R6 partial clear", rd, expC & w);
    end

    // R8 edge-only interrupt, R6 clear all removes it
    wrReg(3'd3, 32'h0);
    wrReg(3'd7, 32'h0);
    pinIn = 32'h0;
    waitCyc(4);
    wrReg(3'd5, 32'h0);
    wrReg(3'd6, 32'h0001_0000);
    pinIn = 32'h0001_0000;
    waitCyc(4);
    chk("R8 edge irq", {31'h0, irq}, 32'h1);
    pinIn = 32'h0;
    waitCyc(4);
    chk("R8 irq held after pin falls", {31'h0, irq}, 32'h1);
    wrReg(3'd5, 32'h0);
    chk("R6 clear all drops irq", {31'h0, irq}, 32'h0);
    // R9 level interrupt follows the pin
    wrReg(3'd6, 32'h0);
    wrReg(3'd7, 32'h0000_0200);
    pinIn = 32'h0000_0200;
    waitCyc(3);
    chk("R9 level irq high", {31'h0, irq}, 32'h1);
    pinIn = 32'h0;
    waitCyc(3);
    chk("R9 level irq low", {31'h0, irq}, 32'h0);

    // R10 blink square wave on pin 7
    wrReg(3'd1, 32'h0);
    wrReg(3'd0, 32'h0);
    wrReg(3'd2, 32'h0000_0080);
    chk("R10 other pins hold data", pinOut & ~32'h80, 32'h0);
    lastT = -1;
    gap = 0;
    rd = pinOut;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (pinOut[7] !== rd[7]) begin
        if (lastT >= 0) begin
          gap++;
          chk("R10 blink half period", 32'(t - lastT), 32'(HALF_BLINK));
        end
        lastT = t;
      end
      rd = pinOut;
    end
    chk("R10 blink toggled", {31'h0, gap > 2}, 32'h1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule